// File: doc/BRIEF.md
# Endpoint Byte Count and Toggle Register

This block holds one endpoint's count-and-status byte. The byte has three fields: a byte count, a flag that says whether the received data is valid, and the DATA0/DATA1 toggle. For a transmit (IN) transaction, firmware writes the number of bytes to send and the toggle to use. For a receive (OUT or SETUP) transaction, the serial engine ends the packet with a one-cycle `rx_done` strobe. That strobe carries the payload length, the toggle seen on the bus and the CRC result. The register then records the payload length plus the two CRC bytes, the toggle and the CRC verdict, and it pulses the endpoint interrupt.

When the `is_ctrl` strap is high, the endpoint is a control endpoint. A hardware update then locks the register against firmware writes until firmware reads it, so a status update cannot be overwritten unseen. When the strap is low, the endpoint never locks. The packet buffers are outside this block.

Top module: `ep_count_reg`

## Requirements
- R1: The register layout is: bits 5..0 hold the byte count, bit 6 holds the data-valid flag, and bit 7 holds the toggle (0 = DATA0, 1 = DATA1). Synchronous reset clears the register to 0x00 and removes any lock.
- R2: An accepted CPU write stores bits 7 and 6 as written. It stores the count field clamped to at most 32, so written counts 0 to 32 are kept unchanged.
- R3: On `rx_done`, the count field becomes `rx_bytes` + 2. When that sum exceeds 34, the count saturates at 34 and data-valid is cleared.
- R4: On `rx_done`, data-valid becomes 1 only if `rx_crc_ok` is 1 and the count did not saturate. Otherwise data-valid becomes 0.
- R5: On `rx_done`, bit 7 takes the value of `rx_toggle`.
- R6: `ep_irq` is high for exactly the one cycle after each `rx_done`, whether or not the CRC was good. It is low after any cycle without `rx_done`.
- R7: When `is_ctrl` is 1, an `rx_done` locks the register, and CPU writes are then ignored. A `cpu_rd` in the same cycle as `rx_done` does not clear the lock that `rx_done` sets.
- R8: When `is_ctrl` is 0, the register never locks, and every CPU write without a simultaneous `rx_done` takes effect.
- R9: When `rx_done` and `cpu_wr` occur in the same cycle, the received values are stored and the CPU write is dropped.
- R10: A `cpu_rd` without `rx_done` removes the lock. A CPU write in the same cycle as that unlocking read is still ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_ctrl | input | 1 | Strap: 1 = control endpoint (locking enabled) |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe (unlocks) |
| cpu_wdata | input | 8 | CPU write data |
| rx_done | input | 1 | Receive-complete strobe for OUT/SETUP |
| rx_bytes | input | 6 | Payload bytes received, CRC excluded |
| rx_toggle | input | 1 | Toggle of the received data packet |
| rx_crc_ok | input | 1 | Received CRC was correct |
| reg_q | output | 8 | Register value |
| ep_irq | output | 1 | One-cycle endpoint interrupt pulse |

## Verification
The assertions assume that `rx_done` and `cpu_wr` are single-cycle strobes sampled at the rising edge. They also assume that `is_ctrl` is a static strap that changes only while no lock is held. The stimulus changes the strap only between vector groups, and only at points where the lock is clear. It drives every input at the falling edge, so each strobe lasts exactly one cycle. Received lengths cover zero, the 32-byte boundary and values past it, so the saturation path runs without violating the range property.

// File: rtl/ep_cnt_pkg.sv
// Package: shared constants and the register field layout for the endpoint
// count register. Assumes the payload plus CRC fits in the count field.
package ep_cnt_pkg;
    localparam int CNT_W       = 6;
    localparam int MAX_PAYLOAD = 32;
    localparam int CRC_BYTES   = 2;
    localparam int REG_W       = CNT_W + 2;

    typedef struct packed {
        logic             tog;
        logic             valid;
        logic [CNT_W-1:0] cnt;
    } ep_stat_t;
endpackage

// File: rtl/ep_rx_fmt.sv
// ep_rx_fmt: turns a receive completion into a register image. It adds the
// CRC bytes, saturates oversize counts and derives data-valid.
// Assumes: inputs are only meaningful while rx_done is high.
module ep_rx_fmt
    import ep_cnt_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int MAXP = MAX_PAYLOAD,
    parameter int CRCB = CRC_BYTES
) (
    input  logic [CW-1:0] rx_bytes,
    input  logic          rx_toggle,
    input  logic          rx_crc_ok,
    output ep_stat_t      rx_img
);
    localparam logic [CW:0] CRC_ADD = (CW+1)'(CRCB);
    localparam logic [CW:0] RX_CAP  = (CW+1)'(MAXP + CRCB);

    logic [CW:0] sum;
    logic        over;

    // Build the received image: count plus CRC, saturated, valid on good CRC.
    always_comb begin
        sum             = {1'b0, rx_bytes} + CRC_ADD;
        over            = (sum > RX_CAP);
        rx_img.tog      = rx_toggle;
        rx_img.valid    = rx_crc_ok && !over;
        rx_img.cnt      = over ? RX_CAP[CW-1:0] : sum[CW-1:0];
    end
endmodule

// File: rtl/ep_cpu_fmt.sv
// ep_cpu_fmt: builds the register image for a CPU write, clamping the
// transmit count to the largest payload. Assumes wdata is REG_W wide.
module ep_cpu_fmt
    import ep_cnt_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int MAXP = MAX_PAYLOAD
) (
    input  logic [CW+1:0] wdata,
    output ep_stat_t      wr_img
);
    localparam logic [CW-1:0] TX_CAP = CW'(MAXP);

    // Keep toggle and valid as written; clamp the count.
    always_comb begin
        wr_img.tog   = wdata[CW+1];
        wr_img.valid = wdata[CW];
        wr_img.cnt   = (wdata[CW-1:0] > TX_CAP) ? TX_CAP : wdata[CW-1:0];
    end
endmodule

// File: rtl/ep_lock_ctl.sv
// ep_lock_ctl: lock flag for the control endpoint. A hardware update sets
// it (and beats a same-cycle read); a read clears it. Non-control endpoints
// never hold the lock. Assumes a synchronous active-low reset.
module ep_lock_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic is_ctrl,
    input  logic hw_upd,
    input  logic cpu_rd,
    output logic locked
);
    // Track the lock: set on a control-endpoint update, clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n)                locked <= 1'b0;
        else if (!is_ctrl)         locked <= 1'b0;
        else if (hw_upd)           locked <= 1'b1;
        else if (cpu_rd)           locked <= 1'b0;
    end

    AST_LOCK_ONLY_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_ctrl) |=> !locked); // R8
    AST_RD_BEFORE_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl && hw_upd && cpu_rd) |=> locked); // R7
endmodule

// File: rtl/ep_count_reg.sv
// ep_count_reg: one endpoint's count/valid/toggle register. It takes CPU
// writes and receive completions, and raises a one-cycle interrupt per
// completion. Assumes rx_done and cpu_wr are single-cycle strobes.
module ep_count_reg
    import ep_cnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_ctrl,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic [REG_W-1:0] cpu_wdata,
    input  logic             rx_done,
    input  logic [CNT_W-1:0] rx_bytes,
    input  logic             rx_toggle,
    input  logic             rx_crc_ok,
    output logic [REG_W-1:0] reg_q,
    output logic             ep_irq
);
    ep_stat_t stat_q, rx_img, wr_img;
    logic     locked, wr_ok;

    ep_rx_fmt #(.CW(CNT_W), .MAXP(MAX_PAYLOAD), .CRCB(CRC_BYTES)) rx_fmt_i (
        .rx_bytes (rx_bytes),
        .rx_toggle(rx_toggle),
        .rx_crc_ok(rx_crc_ok),
        .rx_img   (rx_img)
    );

    ep_cpu_fmt #(.CW(CNT_W), .MAXP(MAX_PAYLOAD)) cpu_fmt_i (
        .wdata (cpu_wdata),
        .wr_img(wr_img)
    );

    ep_lock_ctl lock_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .is_ctrl(is_ctrl),
        .hw_upd (rx_done),
        .cpu_rd (cpu_rd),
        .locked (locked)
    );

    // A CPU write lands only when unlocked and not colliding with hardware.
    assign wr_ok = cpu_wr && !rx_done && !locked;

    // Register update: hardware completion first, then an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)      stat_q <= '0;
        else if (rx_done) stat_q <= rx_img;
        else if (wr_ok)  stat_q <= wr_img;
    end

    // Interrupt pulse one cycle after each completion.
    always_ff @(posedge clk) begin
        if (!rst_n) ep_irq <= 1'b0;
        else        ep_irq <= rx_done;
    end

    assign reg_q = stat_q;

    AST_RX_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> (reg_q[CNT_W-1:0] >= CNT_W'(CRC_BYTES)) &&
                    (reg_q[CNT_W-1:0] <= CNT_W'(MAX_PAYLOAD + CRC_BYTES))); // R3
    AST_BAD_CRC_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_crc_ok) |=> !reg_q[CNT_W]); // R4
    AST_RX_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> (reg_q[CNT_W+1] == $past(rx_toggle))); // R5
    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> ep_irq); // R6
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> !ep_irq); // R6
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !rx_done) |=> $stable(reg_q)); // R10
    AST_TX_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !rx_done && !locked) |=> (reg_q[CNT_W-1:0] <= CNT_W'(MAX_PAYLOAD))); // R2
    AST_NONCTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_ctrl && cpu_wr && !rx_done) |=> (reg_q[CNT_W+1:CNT_W] == $past(cpu_wdata[CNT_W+1:CNT_W]))); // R8
endmodule

// File: tb/ep_count_reg_tb.sv
// Bench for ep_count_reg: a table of vectors walked in order, followed by
// directed reset checks.
module ep_count_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n, is_ctrl, cpu_wr, cpu_rd, rx_done, rx_toggle, rx_crc_ok;
    logic [7:0] cpu_wdata;
    logic [5:0] rx_bytes;
    logic [7:0] reg_q;
    logic       ep_irq;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    ep_count_reg dut_i (
        .clk(clk), .rst_n(rst_n), .is_ctrl(is_ctrl), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .rx_done(rx_done),
        .rx_bytes(rx_bytes), .rx_toggle(rx_toggle), .rx_crc_ok(rx_crc_ok),
        .reg_q(reg_q), .ep_irq(ep_irq)
    );

    // fields: ctrl, wr, rd, wdata, rxd, rxcnt, rxtog, crc, exp_q, exp_irq
    localparam int NV = 19;
    localparam logic [28:0] VEC [NV] = '{
        {1'b0,1'b1,1'b0,8'h85,1'b0,6'd0, 1'b0,1'b0,8'h85,1'b0}, // R2 plain write
        {1'b0,1'b1,1'b0,8'h3F,1'b0,6'd0, 1'b0,1'b0,8'h20,1'b0}, // R2 clamp 63->32
        {1'b0,1'b1,1'b0,8'h60,1'b0,6'd0, 1'b0,1'b0,8'h60,1'b0}, // R2 32 kept, valid as written
        {1'b0,1'b0,1'b0,8'h00,1'b1,6'd10,1'b1,1'b1,8'hCC,1'b1}, // R3 R4 R5 R6
        {1'b0,1'b0,1'b0,8'h00,1'b0,6'd0, 1'b0,1'b0,8'hCC,1'b0}, // R6 pulse ends
        {1'b0,1'b1,1'b0,8'h03,1'b0,6'd0, 1'b0,1'b0,8'h03,1'b0}, // R8 no lock
        {1'b0,1'b0,1'b0,8'h00,1'b1,6'd0, 1'b0,1'b0,8'h02,1'b1}, // R3 R4 bad CRC, irq anyway
        {1'b0,1'b0,1'b0,8'h00,1'b1,6'd32,1'b1,1'b1,8'hE2,1'b1}, // R3 34 boundary
        {1'b0,1'b0,1'b0,8'h00,1'b1,6'd40,1'b0,1'b1,8'h22,1'b1}, // R3 saturate
        {1'b0,1'b1,1'b0,8'h10,1'b1,6'd5, 1'b0,1'b1,8'h47,1'b1}, // R9 hw wins
        {1'b1,1'b1,1'b0,8'h11,1'b0,6'd0, 1'b0,1'b0,8'h11,1'b0}, // R7 unlocked write
        {1'b1,1'b0,1'b0,8'h00,1'b1,6'd8, 1'b1,1'b1,8'hCA,1'b1}, // R7 lock set
        {1'b1,1'b1,1'b0,8'h05,1'b0,6'd0, 1'b0,1'b0,8'hCA,1'b0}, // R7 write ignored
        {1'b1,1'b1,1'b1,8'h06,1'b0,6'd0, 1'b0,1'b0,8'hCA,1'b0}, // R10 write with read ignored
        {1'b1,1'b1,1'b0,8'h06,1'b0,6'd0, 1'b0,1'b0,8'h06,1'b0}, // R10 unlocked
        {1'b1,1'b0,1'b1,8'h00,1'b1,6'd3, 1'b0,1'b0,8'h05,1'b1}, // R7 read with update
        {1'b1,1'b1,1'b0,8'h1F,1'b0,6'd0, 1'b0,1'b0,8'h05,1'b0}, // R7 still locked
        {1'b1,1'b0,1'b1,8'h00,1'b0,6'd0, 1'b0,1'b0,8'h05,1'b0}, // R10 read unlocks
        {1'b1,1'b1,1'b0,8'h21,1'b0,6'd0, 1'b0,1'b0,8'h20,1'b0}  // R2 clamp 33->32
    };
    localparam int REQ [NV] = '{2,2,2,3,6,8,4,3,3,9,7,7,7,10,10,7,7,10,2};

    task automatic check(input int req, input logic [7:0] q, input logic irq);
        n_chk++;
        if (reg_q !== q || ep_irq !== irq) begin
            n_bad++;
            $display("FAIL R%0d: reg_q=%02h irq=%0b expected reg_q=%02h irq=%0b",
                     req, reg_q, ep_irq, q, irq);
        end
    endtask

    task automatic idle();
        cpu_wr = 0; cpu_rd = 0; cpu_wdata = 0; rx_done = 0;
        rx_bytes = 0; rx_toggle = 0; rx_crc_ok = 0;
    endtask

    initial begin
        rst_n = 0; is_ctrl = 0; idle();
        repeat (3) @(negedge clk);
        check(1, 8'h00, 1'b0); // R1 reset state
        rst_n = 1;
        for (int i = 0; i < NV; i++) begin
            {is_ctrl, cpu_wr, cpu_rd, cpu_wdata, rx_done, rx_bytes,
             rx_toggle, rx_crc_ok} = VEC[i][28:9];
            @(negedge clk);
            check(REQ[i], VEC[i][8:1], VEC[i][0]);
        end
        // R1: reset clears register and lock
        idle(); rx_done = 1; rx_bytes = 6'd1; rx_crc_ok = 1;
        @(negedge clk);
        check(7, 8'h43, 1'b1);
        idle(); rst_n = 0;
        @(negedge clk);
        check(1, 8'h00, 1'b0);
        rst_n = 1; cpu_wr = 1; cpu_wdata = 8'h9E;
        @(negedge clk);
        check(1, 8'h9E, 1'b0); // R1 lock gone after reset
        idle();
        @(negedge clk);
        check(6, 8'h9E, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule